// File: doc/BRIEF.md
# RTC Snapshot and Wakeup Register Bank

This block sits between a free-running 32-bit real-time counter and a byte-wide register bus. Software reads the counter through four snapshot registers. The snapshot is refreshed only when software writes to one of those four offsets, so a multi-byte read always returns one coherent value. Reading the snapshot never refreshes it.

The block also holds a 32-bit alarm setting. A one-cycle match pulse goes to the power controller when the live counter reaches a non-zero alarm value.

A control/status byte carries three things. It holds the polarity select for an infrared input and shows the resulting infrared level. It shows the two wakeup latch flags kept by the power controller. It also has two write-one clear bits, which send a one-cycle clear pulse back to the matching latch.

Top module: `rtc_snap_bank`

## Requirements
- R1: After reset, every readable offset (0 to 8) reads 0 while the inputs are low. The outputs `ir_out`, `ir_latch_clr`, `rtc_latch_clr` and `alarm_hit` are all low.
- R2: A bus write to any offset 0 to 3 loads the full `rtc_count` value present at that clock edge into the snapshot. The write data is ignored.
- R3: Offset 0 reads snapshot bits 31:24, offset 1 reads bits 23:16, offset 2 reads bits 15:8 and offset 3 reads bits 7:0. Reading and counter changes leave the snapshot unchanged.
- R4: Offsets 4 to 7 are read/write alarm bytes with the same big-endian order (offset 4 holds bits 31:24). A write updates only the addressed byte.
- R5: Bit 1 of offset 8 is a read/write polarity bit. `ir_out` and bit 0 of offset 8 both equal `ir_in` XOR polarity, with no clock delay.
- R6: Bit 4 of offset 8 reads `ir_latch_in` and bit 5 reads `rtc_latch_in`.
- R7: Writing offset 8 with bit 6 set pulses `ir_latch_clr` high for the single cycle after the write edge. Bit 7 does the same for `rtc_latch_clr`. A 0 in either bit gives no pulse, and bits 6 and 7 always read 0.
- R8: `alarm_hit` is high for exactly one cycle, one clock after the first cycle in which `rtc_count` equals a non-zero alarm value. It stays low while that equality persists.
- R9: While the alarm value is 0, `alarm_hit` stays low even when `rtc_count` is 0.
- R10: Offsets 9 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rtc_count | input | 32 | Live counter value |
| ir_in | input | 1 | Infrared input |
| ir_latch_in | input | 1 | Infrared wakeup latch flag from the power controller |
| rtc_latch_in | input | 1 | RTC wakeup latch flag from the power controller |
| ir_out | output | 1 | Polarity-adjusted infrared level |
| ir_latch_clr | output | 1 | One-cycle clear pulse for the infrared latch |
| rtc_latch_clr | output | 1 | One-cycle clear pulse for the RTC latch |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The bench changes the counter between capture and read-back. A design that captured on reads, or tracked the counter live, would return the new value instead of the held one. It writes a single alarm byte and checks its neighbours, which catches a reversed byte order or a write that spills into other lanes. It holds the counter at the alarm value for several cycles and also sets the alarm to zero with the counter at zero. A level-style or unguarded comparator would then give a stuck-high or spurious `alarm_hit`. It also writes clear commands with the clear bits set and cleared, to expose a clear pulse that fires on any control write or lasts more than one cycle.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int CNT_W  = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  // control/status byte field positions
  localparam int CTL_IR_OUT  = 0;
  localparam int CTL_POL     = 1;
  localparam int CTL_IR_LAT  = 4;
  localparam int CTL_RTC_LAT = 5;
  localparam int CTL_IR_CLR  = 6;
  localparam int CTL_RTC_CLR = 7;

  // bit position of the least significant bit of big-endian lane idx
  function automatic int lane_lsb(input int idx, input int nlanes, input int bw);
    return (nlanes - 1 - idx) * bw;
  endfunction

  // alarm comparison, a zero setting never matches
  function automatic logic alarm_match(input logic [CNT_W-1:0] count,
                                       input logic [CNT_W-1:0] setting);
    return (setting != '0) && (count == setting);
  endfunction
endpackage

// File: rtl/rtc_snap_capture.sv
module rtc_snap_capture #(
  parameter int CNT_W = rtc_snap_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap <= '0;
    else if (load) snap <= live;
  end
endmodule

// File: rtl/rtc_snap_alarm.sv
module rtc_snap_alarm #(
  parameter int CNT_W  = rtc_snap_pkg::CNT_W,
  parameter int BYTE_W = rtc_snap_pkg::BYTE_W,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  alarm_q,
  output logic              match_now,
  output logic              hit
);
  logic match_d;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int LSB = rtc_snap_pkg::lane_lsb(i, NB, BYTE_W);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          alarm_q[LSB +: BYTE_W] <= '0;
      else if (lane_we[i]) alarm_q[LSB +: BYTE_W] <= wdata;
    end
  end

  assign match_now = rtc_snap_pkg::alarm_match(count, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d <= 1'b0;
      hit     <= 1'b0;
    end else begin
      match_d <= match_now;
      hit     <= match_now & ~match_d;
    end
  end
endmodule

// File: rtl/rtc_snap_wake.sv
module rtc_snap_wake #(
  parameter int BYTE_W = rtc_snap_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ir_in,
  output logic              pol_q,
  output logic              ir_out,
  output logic              ir_clr,
  output logic              rtc_clr
);
  import rtc_snap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= 1'b0;
      ir_clr  <= 1'b0;
      rtc_clr <= 1'b0;
    end else begin
      if (ctrl_we) pol_q <= wdata[CTL_POL];
      ir_clr  <= ctrl_we & wdata[CTL_IR_CLR];
      rtc_clr <= ctrl_we & wdata[CTL_RTC_CLR];
    end
  end

  assign ir_out = ir_in ^ pol_q;
endmodule

// File: rtl/rtc_snap_bank.sv
module rtc_snap_bank #(
  parameter int CNT_W  = rtc_snap_pkg::CNT_W,
  parameter int BYTE_W = rtc_snap_pkg::BYTE_W,
  parameter int ADDR_W = rtc_snap_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  rtc_count,
  input  logic              ir_in,
  input  logic              ir_latch_in,
  input  logic              rtc_latch_in,
  output logic              ir_out,
  output logic              ir_latch_clr,
  output logic              rtc_latch_clr,
  output logic              alarm_hit
);
  import rtc_snap_pkg::*;

  localparam int NB         = CNT_W / BYTE_W;
  localparam int SNAP_BASE  = 0;
  localparam int ALARM_BASE = NB;
  localparam int CTRL_OFS   = 2 * NB;

  // named internal events
  logic [NB-1:0]    snap_hit_vec;
  logic [NB-1:0]    alarm_we_vec;
  logic             snap_wr;
  logic             ctrl_wr;
  logic             match_now;
  logic             pol_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] alarm_q;

  for (genvar i = 0; i < NB; i++) begin : g_dec
    assign snap_hit_vec[i] = bus_wr && (bus_addr == ADDR_W'(SNAP_BASE + i));
    assign alarm_we_vec[i] = bus_wr && (bus_addr == ADDR_W'(ALARM_BASE + i));
  end
  assign snap_wr = |snap_hit_vec;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));

  rtc_snap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (snap_wr),
    .live (rtc_count),
    .snap (snap_q)
  );

  rtc_snap_alarm #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (alarm_we_vec),
    .wdata    (bus_wdata),
    .count    (rtc_count),
    .alarm_q  (alarm_q),
    .match_now(match_now),
    .hit      (alarm_hit)
  );

  rtc_snap_wake #(.BYTE_W(BYTE_W)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_we(ctrl_wr),
    .wdata  (bus_wdata),
    .ir_in  (ir_in),
    .pol_q  (pol_q),
    .ir_out (ir_out),
    .ir_clr (ir_latch_clr),
    .rtc_clr(rtc_latch_clr)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == ADDR_W'(SNAP_BASE + i))
        bus_rdata = snap_q[lane_lsb(i, NB, BYTE_W) +: BYTE_W];
      if (bus_addr == ADDR_W'(ALARM_BASE + i))
        bus_rdata = alarm_q[lane_lsb(i, NB, BYTE_W) +: BYTE_W];
    end
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin
      bus_rdata[CTL_IR_OUT]  = ir_out;
      bus_rdata[CTL_POL]     = pol_q;
      bus_rdata[CTL_IR_LAT]  = ir_latch_in;
      bus_rdata[CTL_RTC_LAT] = rtc_latch_in;
    end
  end
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk #(
  parameter int CNT_W  = rtc_snap_pkg::CNT_W,
  parameter int BYTE_W = rtc_snap_pkg::BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snap_wr,
  input logic              ctrl_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  rtc_count,
  input logic [CNT_W-1:0]  snap_q,
  input logic [CNT_W-1:0]  alarm_q,
  input logic              alarm_hit,
  input logic              ir_latch_clr,
  input logic              rtc_latch_clr
);
  import rtc_snap_pkg::*;

  // R2: a snapshot write loads the counter seen at that edge
  p_snap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> (snap_q == $past(rtc_count)));

  // R3: without a snapshot write the held value does not move
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(snap_q));

  // R7: clear pulses follow a write of one, and only that
  p_ir_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CTL_IR_CLR]) |=> ir_latch_clr);
  p_ir_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && bus_wdata[CTL_IR_CLR]) |=> !ir_latch_clr);
  p_rtc_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && bus_wdata[CTL_RTC_CLR]) |=> !rtc_latch_clr);

  // R8: the match pulse never lasts two cycles
  p_hit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit);

  // R9: a zero alarm setting never produces a pulse
  p_zero_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q == '0) |=> !alarm_hit);
endmodule

bind rtc_snap_bank rtc_snap_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snap_wr      (snap_wr),
  .ctrl_wr      (ctrl_wr),
  .bus_wdata    (bus_wdata),
  .rtc_count    (rtc_count),
  .snap_q       (snap_q),
  .alarm_q      (alarm_q),
  .alarm_hit    (alarm_hit),
  .ir_latch_clr (ir_latch_clr),
  .rtc_latch_clr(rtc_latch_clr)
);

// File: tb/rtc_snap_bank_tb_top.sv
module rtc_snap_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] rtc_count = '0;
  logic        ir_in = 1'b0, ir_latch_in = 1'b0, rtc_latch_in = 1'b0;
  logic        ir_out, ir_latch_clr, rtc_latch_clr, alarm_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // observation kinds: 0 rdata, 1 ir_out, 2 ir clear, 3 rtc clear, 4 alarm pulse
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  rtc_snap_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_count(rtc_count),
    .ir_in(ir_in), .ir_latch_in(ir_latch_in), .rtc_latch_in(rtc_latch_in),
    .ir_out(ir_out), .ir_latch_clr(ir_latch_clr),
    .rtc_latch_clr(rtc_latch_clr), .alarm_hit(alarm_hit)
  );

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = {24'd0, bus_rdata};
        1: act = {31'd0, ir_out};
        2: act = {31'd0, ir_latch_clr};
        3: act = {31'd0, rtc_latch_clr};
        default: act = {31'd0, alarm_hit};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] exp, input string req);
    exp_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cycle();
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input logic [3:0] a, input logic [7:0] exp, input string req);
    bus_addr = a;
    expect_item(0, {24'd0, exp}, req);
    @(negedge clk); #1;
  endtask

  task automatic pulse_check(input logic ir_e, input logic rtc_e, input logic hit_e,
                             input string req);
    expect_item(2, {31'd0, ir_e}, req);
    expect_item(3, {31'd0, rtc_e}, req);
    expect_item(4, {31'd0, hit_e}, req);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();

    // R1 reset state
    for (int a = 0; a < 9; a++) read_check(4'(a), 8'h00, "R1");
    expect_item(1, 32'd0, "R1");
    pulse_check(1'b0, 1'b0, 1'b0, "R1");

    // R2 / R3 capture through offset 2, data ignored
    rtc_count = 32'hA1B2_C3D4;
    bus_write(4'd2, 8'hFF);
    rtc_count = 32'h1122_3344;
    read_check(4'd0, 8'hA1, "R3");
    read_check(4'd1, 8'hB2, "R3");
    read_check(4'd2, 8'hC3, "R3");
    read_check(4'd3, 8'hD4, "R3");
    cycle();
    read_check(4'd0, 8'hA1, "R3 hold after reads");
    bus_write(4'd0, 8'h00);
    read_check(4'd0, 8'h11, "R2");
    read_check(4'd3, 8'h44, "R2");
    rtc_count = 32'h5566_7788;
    bus_write(4'd3, 8'h12);
    read_check(4'd1, 8'h66, "R2 offset 3");

    // R4 alarm bytes, big-endian, per-byte write
    rtc_count = 32'h1234_5678;
    bus_write(4'd4, 8'h00);
    bus_write(4'd5, 8'h00);
    bus_write(4'd6, 8'h01);
    bus_write(4'd7, 8'h00);
    read_check(4'd6, 8'h01, "R4");
    bus_write(4'd7, 8'h05);
    read_check(4'd6, 8'h01, "R4 neighbour");
    read_check(4'd7, 8'h05, "R4");
    read_check(4'd5, 8'h00, "R4 neighbour");

    // R8 alarm = 0x105
    rtc_count = 32'h104;
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R8 no match");
    rtc_count = 32'h105;
    cycle();
    pulse_check(1'b0, 1'b0, 1'b1, "R8 first match");
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R8 held match");
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R8 held match");
    rtc_count = 32'h106;
    cycle();
    rtc_count = 32'h105;
    cycle();
    pulse_check(1'b0, 1'b0, 1'b1, "R8 rematch");

    // R9 zero alarm
    rtc_count = 32'h1234_5678;
    bus_write(4'd6, 8'h00);
    bus_write(4'd7, 8'h00);
    rtc_count = 32'h0;
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R9");
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R9");

    // R5 polarity
    bus_write(4'd8, 8'h02);
    ir_in = 1'b1;
    expect_item(1, 32'd0, "R5");
    read_check(4'd8, 8'h02, "R5");
    ir_in = 1'b0;
    expect_item(1, 32'd1, "R5");
    read_check(4'd8, 8'h03, "R5");

    // R6 latch flags
    ir_latch_in = 1'b1;
    read_check(4'd8, 8'h13, "R6");
    rtc_latch_in = 1'b1;
    ir_latch_in = 1'b0;
    read_check(4'd8, 8'h23, "R6");
    rtc_latch_in = 1'b0;

    // R7 clear pulses
    bus_write(4'd8, 8'h42);
    pulse_check(1'b1, 1'b0, 1'b0, "R7 ir clear");
    cycle();
    pulse_check(1'b0, 1'b0, 1'b0, "R7 pulse ends");
    read_check(4'd8, 8'h03, "R7 clear bits read 0");
    bus_write(4'd8, 8'h82);
    pulse_check(1'b0, 1'b1, 1'b0, "R7 rtc clear");
    bus_write(4'd8, 8'h02);
    pulse_check(1'b0, 1'b0, 1'b0, "R7 zero no pulse");

    // R10 unmapped offsets
    bus_write(4'd12, 8'hFF);
    bus_write(4'd9, 8'hFF);
    read_check(4'd12, 8'h00, "R10");
    read_check(4'd15, 8'h00, "R10");
    read_check(4'd4, 8'h00, "R10 alarm untouched");
    read_check(4'd8, 8'h03, "R10 control untouched");
    read_check(4'd0, 8'h55, "R10 snapshot untouched");
    pulse_check(1'b0, 1'b0, 1'b0, "R10");

    cycle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule